// File: doc/BRIEF.md
# Power-Management Timer and Event Status Block

This block keeps a free-running power-management counter and three 16-bit registers: event status, event enable and power control. Software reaches them through a 64-byte I/O window. Word accesses reach the three registers. A dword read at offset 0x08 returns the counter. A single tick-enable input advances the counter. In a full system that input is driven at the 3.579545 MHz timer rate, or by a divider from a faster clock.

Status bits are set by hardware events and cleared by software, which writes a one to each bit it wants to clear. A counter overflow sets its own status bit each time the counter's top bit changes. The block drives a level interrupt, `sci`, for as long as any status bit is both set and enabled. A write to the control register with the sleep bit set is a command and is not stored. If the sleep-type field is zero, the command produces a one-cycle soft-off request.

A sideband pair lets an external command port set or clear the interrupt-enable bit of the control register.

Top module: `acpi_pm_evt`

## Requirements
- R1: The counter adds one on every clock edge where `tick_en` is high. A dword read at offset 0x08 returns the low TMR_W bits of the counter (24 by default) with every higher bit zero.
- R2: The status register sits at word offset 0x00. A write clears each status bit whose data bit is 1 and leaves the others unchanged. `hw_evt[0]` sets bit 5, `hw_evt[1]` sets bit 8 and `hw_evt[2]` sets bit 10. When a set and a clear hit the same bit in the same cycle, the set wins. Bits outside 0, 5, 8 and 10 always read 0.
- R3: Status bit 0 sets on the tick that changes counter bit TMR_W-1. That happens at each multiple of 2^(TMR_W-1), including the wrap to zero. After software clears bit 0, it sets again at the next such boundary.
- R4: The enable register sits at word offset 0x02 and stores all 16 bits. The control register sits at word offset 0x04 and stores every bit except bit 13. Read data appears on `rd_data` with `rd_valid` on the cycle after the read access.
- R5: `sci` is a registered output. One cycle after any change to status or enable, it equals the OR of (status AND enable) over bits 0, 5, 8 and 10.
- R6: Control bit 13 is a command and is never stored, so reads of the control register always return 0 in bit 13.
- R7: A word write to offset 0x04 with bit 13 set and bits 11:10 equal to 0 makes `shutdown_req` high for exactly one cycle, the cycle after the write. With any other value in bits 11:10, the command produces no pulse.
- R8: Word reads at offsets other than 0x00, 0x02 and 0x04 return 0. Dword reads at offsets other than 0x08 return 0. Dword writes change nothing.
- R9: A pulse on `sci_en_set` sets control bit 0 and a pulse on `sci_en_clr` clears it. If both are high in the same cycle, the clear wins.
- R10: A synchronous active-high reset clears the counter, all three registers, `sci`, `shutdown_req` and `rd_valid`. The first overflow after reset comes at counter value 2^(TMR_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the counter by one on this edge |
| acc_valid | input | 1 | An I/O access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dword | input | 1 | 1 = dword access, 0 = word access |
| acc_addr | input | 6 | Byte offset inside the window |
| wr_data | input | 32 | Write data; word writes use bits 15:0 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| hw_evt | input | 3 | Event pulses: global, power button, RTC |
| sci_en_set | input | 1 | Sideband set of control bit 0 |
| sci_en_clr | input | 1 | Sideband clear of control bit 0 |
| sci | output | 1 | Level interrupt |
| shutdown_req | output | 1 | One-cycle soft-off request |

## Verification
Some properties hold on every cycle, and the assertions check them continuously:
- the counter steps only on `tick_en`;
- timer reads carry zero upper bits;
- undefined word reads return zero;
- bit 13 of the control register never reads back as 1;
- `shutdown_req` stays high for only one cycle, and only after a soft-off write;
- `sci` stays low whenever enable was zero.

Other behaviour depends on a sequence of steps, and only the bench scenarios can show it. This covers:
- the overflow flag setting at both the midpoint and the wrap boundaries, and re-arming after a clear;
- write-one-to-clear against a simultaneous event;
- the one-cycle lag of `sci`;
- non-zero sleep types being ignored;
- the priority between the sideband set and clear.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int unsigned REG_W      = 16;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned OFS_W      = 6;
    localparam int unsigned NUM_HW_EVT = 3;

    localparam logic [OFS_W-1:0] OFS_STS = 6'h00;
    localparam logic [OFS_W-1:0] OFS_EN  = 6'h02;
    localparam logic [OFS_W-1:0] OFS_CTL = 6'h04;
    localparam logic [OFS_W-1:0] OFS_TMR = 6'h08;

    localparam int unsigned BIT_TMROF  = 0;
    localparam int unsigned BIT_GBL    = 5;
    localparam int unsigned BIT_PWRBTN = 8;
    localparam int unsigned BIT_RTC    = 10;
    localparam int unsigned BIT_SLEEP  = 13;
    localparam int unsigned BIT_SCI_EN = 0;
    localparam int unsigned TYP_LO     = 10;

    localparam logic [REG_W-1:0] STS_LIVE =
        (REG_W'(1) << BIT_TMROF) | (REG_W'(1) << BIT_GBL) |
        (REG_W'(1) << BIT_PWRBTN) | (REG_W'(1) << BIT_RTC);

    typedef enum logic [1:0] {
        SLP_SOFT_OFF = 2'd0,
        SLP_TYPE_1   = 2'd1,
        SLP_TYPE_2   = 2'd2,
        SLP_TYPE_3   = 2'd3
    } slp_typ_e;

    typedef struct packed {
        logic     req;
        slp_typ_e typ;
    } sleep_cmd_t;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] ctl;
    } pm_regs_t;

    // Status bit position driven by each hardware event input.
    function automatic int unsigned hw_evt_bit(input int unsigned idx);
        case (idx)
            0:       return BIT_GBL;
            1:       return BIT_PWRBTN;
            default: return BIT_RTC;
        endcase
    endfunction

    function automatic sleep_cmd_t decode_sleep(input logic [REG_W-1:0] val);
        sleep_cmd_t c;
        c.req = val[BIT_SLEEP];
        c.typ = slp_typ_e'(val[TYP_LO +: 2]);
        return c;
    endfunction

endpackage

// File: rtl/pm_tmr_counter.sv
module pm_tmr_counter #(
    parameter int unsigned TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [TMR_W-1:0] count,
    output logic             ovf_evt
);
    localparam int unsigned TOP = TMR_W - 1;

    logic [TMR_W-1:0] cnt_next;

    assign cnt_next = count + TMR_W'(1);
    // Overflow event whenever the top bit flips on a tick.
    assign ovf_evt  = tick_en && (count[TOP] != cnt_next[TOP]);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick_en) begin
            count <= cnt_next;
        end
    end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_word,
    input  logic [OFS_W-1:0]      wr_ofs,
    input  logic [REG_W-1:0]      wr_val,
    input  logic                  ovf_evt,
    input  logic [NUM_HW_EVT-1:0] hw_evt,
    input  logic                  sb_set,
    input  logic                  sb_clr,
    output pm_regs_t              regs_q,
    output logic                  sci,
    output logic                  shutdown_req
);
    logic [REG_W-1:0] evt_vec [NUM_HW_EVT];
    logic [REG_W-1:0] set_all;
    logic [REG_W-1:0] clr_vec;
    pm_regs_t         regs_d;
    sleep_cmd_t       cmd;
    logic             shut_d;

    for (genvar g = 0; g < NUM_HW_EVT; g++) begin : g_evt
        assign evt_vec[g] = hw_evt[g] ? (REG_W'(1) << hw_evt_bit(g)) : '0;
    end

    always_comb begin
        set_all = ovf_evt ? (REG_W'(1) << BIT_TMROF) : '0;
        for (int i = 0; i < NUM_HW_EVT; i++) begin
            set_all = set_all | evt_vec[i];
        end
    end

    assign clr_vec = (wr_word && wr_ofs == OFS_STS) ? wr_val : '0;
    assign cmd     = decode_sleep(wr_val);

    always_comb begin
        regs_d     = regs_q;
        regs_d.sts = ((regs_q.sts & ~clr_vec) | set_all) & STS_LIVE;
        if (wr_word && wr_ofs == OFS_EN) begin
            regs_d.en = wr_val;
        end
        if (wr_word && wr_ofs == OFS_CTL) begin
            regs_d.ctl = wr_val & ~(REG_W'(1) << BIT_SLEEP);
        end
        if (sb_clr) begin
            regs_d.ctl[BIT_SCI_EN] = 1'b0;
        end else if (sb_set) begin
            regs_d.ctl[BIT_SCI_EN] = 1'b1;
        end
        shut_d = wr_word && (wr_ofs == OFS_CTL) && cmd.req && (cmd.typ == SLP_SOFT_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q       <= '0;
            sci          <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            regs_q       <= regs_d;
            sci          <= |(regs_q.sts & regs_q.en & STS_LIVE);
            shutdown_req <= shut_d;
        end
    end
endmodule

// File: rtl/pm_rd_mux.sv
module pm_rd_mux
    import pm_evt_pkg::*;
#(
    parameter int unsigned TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             rd_dword,
    input  logic [OFS_W-1:0] rd_ofs,
    input  pm_regs_t         regs_q,
    input  logic [TMR_W-1:0] count,
    output logic             rd_valid,
    output logic [BUS_W-1:0] rd_data
);
    localparam int unsigned PAD_W = BUS_W - TMR_W;

    logic [BUS_W-1:0] rd_d;

    always_comb begin
        rd_d = '0;
        if (rd_dword) begin
            if (rd_ofs == OFS_TMR) begin
                rd_d = {{PAD_W{1'b0}}, count};
            end
        end else begin
            case (rd_ofs)
                OFS_STS: rd_d = BUS_W'(regs_q.sts);
                OFS_EN:  rd_d = BUS_W'(regs_q.en);
                OFS_CTL: rd_d = BUS_W'(regs_q.ctl);
                default: rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_d;
            end
        end
    end
endmodule

// File: rtl/acpi_pm_evt.sv
module acpi_pm_evt
    import pm_evt_pkg::*;
#(
    parameter int unsigned TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_dword,
    input  logic [5:0]  acc_addr,
    input  logic [31:0] wr_data,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    input  logic [2:0]  hw_evt,
    input  logic        sci_en_set,
    input  logic        sci_en_clr,
    output logic        sci,
    output logic        shutdown_req
);
    logic [TMR_W-1:0] tmr_count;
    logic             ovf_evt;
    pm_regs_t         regs_q;
    logic             wr_word;
    logic             rd_en;
    logic             unused_hi;

    assign wr_word   = acc_valid && acc_write && !acc_dword;
    assign rd_en     = acc_valid && !acc_write;
    assign unused_hi = ^wr_data[BUS_W-1:REG_W];

    pm_tmr_counter #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .count   (tmr_count),
        .ovf_evt (ovf_evt)
    );

    pm_evt_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_word      (wr_word),
        .wr_ofs       (acc_addr),
        .wr_val       (wr_data[REG_W-1:0]),
        .ovf_evt      (ovf_evt),
        .hw_evt       (hw_evt),
        .sb_set       (sci_en_set),
        .sb_clr       (sci_en_clr),
        .regs_q       (regs_q),
        .sci          (sci),
        .shutdown_req (shutdown_req)
    );

    pm_rd_mux #(.TMR_W(TMR_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_dword (acc_dword),
        .rd_ofs   (acc_addr),
        .regs_q   (regs_q),
        .count    (tmr_count),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/pm_evt_chk.sv
module pm_evt_chk #(
    parameter int unsigned TMR_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             acc_dword,
    input logic [5:0]       acc_addr,
    input logic             wr_sleep,
    input logic [1:0]       wr_typ,
    input logic             rd_valid,
    input logic [31:0]      rd_data,
    input logic             tick_en,
    input logic [TMR_W-1:0] tmr_count,
    input logic [15:0]      en_q,
    input logic             sci,
    input logic             shutdown_req
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(tick_en) |-> tmr_count == TMR_W'($past(tmr_count) + TMR_W'(1))); // R1
    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(tick_en) |-> $stable(tmr_count)); // R1
    AST_TMR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        past_ok && rd_valid && $past(acc_valid && !acc_write && acc_dword && acc_addr == 6'h08)
        |-> (rd_data >> TMR_W) == 32'd0); // R1
    AST_SCI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(en_q) == 16'd0 |-> !sci); // R5
    AST_SLEEP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        past_ok && rd_valid && $past(acc_valid && !acc_write && !acc_dword && acc_addr == 6'h04)
        |-> !rd_data[13]); // R6
    AST_SHUTDOWN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |=> !shutdown_req); // R7
    AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        past_ok && shutdown_req |-> $past(acc_valid && acc_write && !acc_dword &&
                                          acc_addr == 6'h04 && wr_sleep && wr_typ == 2'b00)); // R7
    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        past_ok && rd_valid && $past(acc_valid && !acc_write && !acc_dword &&
            acc_addr != 6'h00 && acc_addr != 6'h02 && acc_addr != 6'h04)
        |-> rd_data == 32'd0); // R8
endmodule

bind acpi_pm_evt pm_evt_chk #(.TMR_W(TMR_W)) u_pm_evt_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_dword    (acc_dword),
    .acc_addr     (acc_addr),
    .wr_sleep     (wr_data[13]),
    .wr_typ       (wr_data[11:10]),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .tick_en      (tick_en),
    .tmr_count    (tmr_count),
    .en_q         (regs_q.en),
    .sci          (sci),
    .shutdown_req (shutdown_req)
);

// File: tb/test_acpi_pm_evt.sv
module test_acpi_pm_evt;
    localparam int unsigned TW = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic        acc_valid, acc_write, acc_dword;
    logic [5:0]  acc_addr;
    logic [31:0] wr_data;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [2:0]  hw_evt;
    logic        sci_en_set, sci_en_clr;
    logic        sci, shutdown_req;

    always #5 clk = ~clk;

    acpi_pm_evt #(.TMR_W(TW)) i_acpi_pm_evt (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_dword(acc_dword),
        .acc_addr(acc_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .hw_evt(hw_evt), .sci_en_set(sci_en_set), .sci_en_clr(sci_en_clr),
        .sci(sci), .shutdown_req(shutdown_req)
    );

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   fails  = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as results come out.
    always @(negedge clk) begin
        exp_t e;
        if (!rst && rd_valid) begin
            if (sb_q.size() == 0) begin
                check("unexpected read", rd_data, 32'hxxxxxxxx);
            end else begin
                e = sb_q.pop_front();
                check(e.tag, rd_data, e.exp);
            end
        end
    end

    task automatic idle();
        acc_valid = 0; acc_write = 0; acc_dword = 0; acc_addr = '0; wr_data = '0;
        hw_evt = '0; sci_en_set = 0; sci_en_clr = 0;
    endtask

    task automatic wr(input logic dw, input logic [5:0] ofs, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_dword = dw; acc_addr = ofs; wr_data = d;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic dw, input logic [5:0] ofs, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        e.tag = tag; e.exp = exp;
        sb_q.push_back(e);
        acc_valid = 1; acc_write = 0; acc_dword = dw; acc_addr = ofs;
        @(negedge clk);
        idle();
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    task automatic pulse_evt(input logic [2:0] v);
        @(negedge clk);
        hw_evt = v;
        @(negedge clk);
        hw_evt = '0;
    endtask

    task automatic sideband(input logic s, input logic c);
        @(negedge clk);
        sci_en_set = s; sci_en_clr = c;
        @(negedge clk);
        sci_en_set = 0; sci_en_clr = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; tick_en = 0;
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        check("R10 sci after reset", 32'(sci), 0);
        check("R10 shutdown after reset", 32'(shutdown_req), 0);
        rd(0, 6'h00, 0, "R10 status reset");
        rd(0, 6'h02, 0, "R10 enable reset");
        rd(0, 6'h04, 0, "R10 control reset");
        rd(1, 6'h08, 0, "R10 timer reset");

        // R1: counting and timer read
        tick(5);
        rd(1, 6'h08, 5, "R1 timer after 5 ticks");
        rd(1, 6'h0C, 0, "R8 dword read undefined");

        // R3: midpoint boundary
        tick(506);
        rd(0, 6'h00, 0, "R3 no overflow at 511");
        tick(1);
        rd(0, 6'h00, 32'h1, "R3 overflow at 512");
        check("R5 sci low when not enabled", 32'(sci), 0);
        wr(0, 6'h02, 32'h0001);
        @(negedge clk);
        check("R5 sci high after enable", 32'(sci), 1);
        wr(0, 6'h00, 32'h0000);
        rd(0, 6'h00, 32'h1, "R2 write zero keeps status");
        wr(0, 6'h00, 32'h0001);
        @(negedge clk);
        check("R5 sci low after clear", 32'(sci), 0);
        rd(0, 6'h00, 0, "R2 write one clears");

        // R3: wrap boundary, re-armed after clear
        tick(511);
        rd(0, 6'h00, 0, "R3 no overflow at 1023");
        tick(1);
        rd(0, 6'h00, 32'h1, "R3 overflow on wrap");
        rd(1, 6'h08, 0, "R1 timer wrapped to zero");
        wr(0, 6'h00, 32'h0001);

        // R2/R5: hardware events
        pulse_evt(3'b010);
        rd(0, 6'h00, 32'h0100, "R2 power button event");
        check("R5 sci low for unenabled event", 32'(sci), 0);
        wr(0, 6'h02, 32'h0100);
        @(negedge clk);
        check("R5 sci high for enabled event", 32'(sci), 1);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_dword = 0; acc_addr = 6'h00;
        wr_data = 32'h0400; hw_evt = 3'b100;
        @(negedge clk);
        idle();
        rd(0, 6'h00, 32'h0500, "R2 set wins over clear");
        pulse_evt(3'b001);
        rd(0, 6'h00, 32'h0520, "R2 global event");
        wr(0, 6'h00, 32'hFFFF);
        rd(0, 6'h00, 0, "R2 clear all");
        @(negedge clk);
        check("R5 sci low after clear all", 32'(sci), 0);

        // R4/R8: enable register and ignored accesses
        wr(0, 6'h02, 32'hFFFF);
        rd(0, 6'h02, 32'hFFFF, "R4 enable readback");
        wr(1, 6'h02, 32'h0);
        rd(0, 6'h02, 32'hFFFF, "R8 dword write ignored");
        wr(1, 6'h08, 32'h123);
        rd(1, 6'h08, 0, "R8 dword write to timer ignored");
        rd(0, 6'h06, 0, "R8 word read offset 6");
        rd(0, 6'h08, 0, "R8 word read offset 8");
        rd(1, 6'h00, 0, "R8 dword read offset 0");
        wr(0, 6'h02, 32'h0000);

        // R4/R6/R7: control and sleep command
        wr(0, 6'h04, 32'h1C01);
        check("R7 no pulse without sleep bit", 32'(shutdown_req), 0);
        rd(0, 6'h04, 32'h1C01, "R4 control readback");
        wr(0, 6'h04, 32'h2400);
        check("R7 no pulse for type 1", 32'(shutdown_req), 0);
        @(negedge clk);
        check("R7 still no pulse for type 1", 32'(shutdown_req), 0);
        rd(0, 6'h04, 32'h0400, "R6 sleep bit not stored");
        wr(0, 6'h04, 32'h2000);
        check("R7 pulse for soft-off", 32'(shutdown_req), 1);
        @(negedge clk);
        check("R7 pulse lasts one cycle", 32'(shutdown_req), 0);
        rd(0, 6'h04, 0, "R6 control after soft-off");
        wr(0, 6'h04, 32'h3C00);
        check("R7 no pulse for type 3", 32'(shutdown_req), 0);
        rd(0, 6'h04, 32'h1C00, "R6 type 3 stored without bit 13");

        // R9: sideband
        sideband(1, 0);
        rd(0, 6'h04, 32'h1C01, "R9 sideband set");
        sideband(1, 1);
        rd(0, 6'h04, 32'h1C00, "R9 clear wins");
        sideband(1, 0);
        sideband(0, 1);
        rd(0, 6'h04, 32'h1C00, "R9 sideband clear");

        // R10: reset in mid-run
        wr(0, 6'h02, 32'h0521);
        tick(7);
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        check("R10 sci after mid reset", 32'(sci), 0);
        rd(1, 6'h08, 0, "R10 timer after mid reset");
        rd(0, 6'h02, 0, "R10 enable after mid reset");
        rd(0, 6'h04, 0, "R10 control after mid reset");
        tick(511);
        rd(0, 6'h00, 0, "R10 not yet armed at 511");
        tick(1);
        rd(0, 6'h00, 32'h1, "R10 first overflow at 512");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) check("R4 pending reads", 32'(sb_q.size()), 0);
        finish_run();
    end
endmodule